// File: doc/BRIEF.md
# Fractional-N Modulus Sequence Generator

This block drives the dual-modulus control of a fractional-N synthesizer's feedback divider. It emits one select bit per reference cycle. A 1 asks the divider to count N+1 for that cycle and a 0 asks for N. When A cycles use N and B cycles use N+1, the long-run division ratio is N + B/(A+B). The block holds that ratio at N + frac/2^K, where frac is an unsigned K-bit input word. For example, with N=4 and K=8, a frac of 64 gives one N+1 cycle in every four. Over four reference cycles that is 17 output cycles, a ratio of 4.25.

The block has one signed residue register that records the accumulated phase error. Each enabled cycle it adds the fraction to the residue, quantizes the sum to a select bit and feeds the quantization error back into the residue. The mode input chooses one of three quantizers, and all three keep the same average ratio:

- The periodic quantizer gives a fixed repeating pattern and a sawtooth residue.
- The randomized quantizer adds pseudo-random dither to the comparison, which breaks up the pattern.
- The sigma-delta quantizer rounds at half scale, which keeps the residue centred on zero and pushes the selection error toward high frequencies.

The residue is brought out so the phase-error ramp can be observed.

Top module: `fracn_modsel`

## Requirements
- R1: Reset is asynchronous and active low. After reset, sel_hi is 0 and phase_err is 0.
- R2: Results are registered and appear at the edge that samples the inputs. On each clock edge with enable high, the new residue equals the old residue plus frac, minus 2^K when the new sel_hi is 1.
- R3: Mode codes 2'b00 and 2'b11 select periodic mode. In this mode sel_hi becomes 1 exactly when residue + frac >= 2^K, and a residue in [0, 2^K) stays in that range.
- R4: In periodic mode, starting from residue 0, exactly frac of every 2^K consecutive enabled cycles have sel_hi = 1. With K=8, frac=64 gives one high bit in every four cycles.
- R5: Mode code 2'b01 selects randomized mode. In this mode sel_hi becomes 1 exactly when residue + frac + d >= 2^K. Here d is the low K-1 bits of a 16-bit LFSR state, read as a signed number, taken before the LFSR advances. The LFSR is seeded with 16'hACE1 and advances on every enabled cycle in every mode. Its step is a right shift, XORed with 16'hB400 when the bit shifted out is 1.
- R6: In randomized mode, the number of high bits over a window of W enabled cycles is within 2 of frac*W/2^K.
- R7: Mode code 2'b10 selects sigma-delta mode. In this mode sel_hi becomes 1 exactly when residue + frac >= 2^(K-1), and a residue in [-2^(K-1), 2^(K-1)) stays in that range.
- R8: With frac = 0 and residue 0, sel_hi stays 0 and the residue stays 0 in every mode.
- R9: While enable is low, sel_hi is 0 after each edge, and the residue and the LFSR hold their values.
- R10: A mode change keeps the residue. In any mix of modes, phase_err stays within [-2^(K-1), 5*2^(K-2)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance the sequence this cycle |
| mode | input | 2 | Quantizer choice: 00 periodic, 01 randomized, 10 sigma-delta, 11 periodic |
| frac | input | FRAC_W | Unsigned fractional part of the ratio, in units of 2^-K |
| sel_hi | output | 1 | Modulus select: 1 means divide by N+1 this cycle |
| phase_err | output | FRAC_W+2 | Signed residue (accumulated phase error), two's complement |

## Verification
A mode change and a quantizer decision can land on the same edge. The decision must then use the new mode's threshold and dither on the residue left by the old mode. The bench reaches this by rotating the mode every seven cycles while the fraction sweeps a coprime stride, so switches hit residues just below and just above each threshold. Enable is dropped on a separate cadence so that some switches also meet a held cycle. A behavioural model carries the residue and the LFSR across those edges, and the bench compares its select bit and residue with the design on every cycle.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
   typedef enum logic [1:0] {
      MODE_PERIODIC = 2'b00,
      MODE_RANDOM   = 2'b01,
      MODE_SIGDEL   = 2'b10,
      MODE_SPARE    = 2'b11
   } fracn_mode_e;
endpackage

// File: rtl/fracn_lfsr.sv
// Galois LFSR, right shifting; exports only the low OUT_W bits as dither.
module fracn_lfsr #(
   parameter int              LFSR_W = 16,
   parameter int              OUT_W  = 7,
   parameter logic [LFSR_W-1:0] POLY = 16'hB400,
   parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [OUT_W-1:0] dither
);
   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] state_d;

   always_comb begin
      state_d = state_q >> 1;
      if (state_q[0]) state_d = state_d ^ POLY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q <= SEED;
      else if (advance) state_q <= state_d;
   end

   assign dither = state_q[OUT_W-1:0];
endmodule

// File: rtl/fracn_quant.sv
// Error-feedback quantizer: compare (residue + frac + dither) with a threshold,
// subtract full scale from the undithered sum when the select bit is set.
module fracn_quant #(
   parameter int FRAC_W = 8,
   parameter int RES_W  = FRAC_W + 2
) (
   input  logic signed [RES_W-1:0]  res,
   input  logic        [FRAC_W-1:0] frac,
   input  logic signed [FRAC_W-2:0] dither,
   input  logic                     half_thr,
   output logic                     sel,
   output logic signed [RES_W-1:0]  res_next
);
   localparam int SUM_W = RES_W + 1;
   localparam logic signed [SUM_W-1:0] THR_FULL = SUM_W'(1) <<< FRAC_W;
   localparam logic signed [SUM_W-1:0] THR_HALF = SUM_W'(1) <<< (FRAC_W - 1);
   localparam logic signed [RES_W-1:0] SUB_FULL = RES_W'(1) <<< FRAC_W;

   logic signed [SUM_W-1:0] sum_raw;
   logic signed [SUM_W-1:0] sum_dith;

   always_comb begin
      sum_raw  = $signed({res[RES_W-1], res}) + $signed({{(SUM_W-FRAC_W){1'b0}}, frac});
      sum_dith = sum_raw + $signed({{(SUM_W-FRAC_W+1){dither[FRAC_W-2]}}, dither});
      sel      = (sum_dith >= (half_thr ? THR_HALF : THR_FULL));
      res_next = sum_raw[RES_W-1:0] - (sel ? SUB_FULL : '0);
   end
endmodule

// File: rtl/fracn_modsel.sv
module fracn_modsel #(
   parameter int          FRAC_W     = 8,
   parameter int          LFSR_W     = 16,
   parameter logic [LFSR_W-1:0] LFSR_POLY = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   parameter bit          USE_DITHER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        mode,
   input  logic [FRAC_W-1:0] frac,
   output logic              sel_hi,
   output logic [FRAC_W+1:0] phase_err
);
   localparam int RES_W = FRAC_W + 2;
   localparam int DIT_W = FRAC_W - 1;

   if (FRAC_W < 3) begin : g_bad_frac
      $error("fracn_modsel: FRAC_W must be at least 3");
   end
   if (USE_DITHER && LFSR_W < DIT_W) begin : g_bad_lfsr
      $error("fracn_modsel: LFSR_W must cover FRAC_W-1 dither bits");
   end
   if (USE_DITHER && LFSR_SEED == '0) begin : g_bad_seed
      $error("fracn_modsel: LFSR_SEED must be nonzero");
   end

   fracn_pkg::fracn_mode_e mode_e;
   assign mode_e = fracn_pkg::fracn_mode_e'(mode);

   logic signed [RES_W-1:0] res_q;
   logic signed [RES_W-1:0] res_d;
   logic                    sel_q;
   logic                    sel_d;
   logic        [DIT_W-1:0] lfsr_bits;
   logic signed [DIT_W-1:0] dither_eff;
   logic                    half_thr;

   if (USE_DITHER) begin : g_dither
      fracn_lfsr #(
         .LFSR_W (LFSR_W),
         .OUT_W  (DIT_W),
         .POLY   (LFSR_POLY),
         .SEED   (LFSR_SEED)
      ) u_lfsr (
         .clk     (clk),
         .rst_n   (rst_n),
         .advance (enable),
         .dither  (lfsr_bits)
      );
   end else begin : g_no_dither
      assign lfsr_bits = '0;
   end

   always_comb begin
      half_thr   = (mode_e == fracn_pkg::MODE_SIGDEL);
      dither_eff = (mode_e == fracn_pkg::MODE_RANDOM) ? $signed(lfsr_bits) : '0;
   end

   fracn_quant #(
      .FRAC_W (FRAC_W),
      .RES_W  (RES_W)
   ) u_quant (
      .res      (res_q),
      .frac     (frac),
      .dither   (dither_eff),
      .half_thr (half_thr),
      .sel      (sel_d),
      .res_next (res_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         sel_q <= 1'b0;
      end else if (enable) begin
         res_q <= res_d;
         sel_q <= sel_d;
      end else begin
         sel_q <= 1'b0;
      end
   end

   assign sel_hi    = sel_q;
   assign phase_err = res_q;
endmodule

// File: rtl/fracn_modsel_chk.sv
module fracn_modsel_chk #(
   parameter int FRAC_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic [1:0]        mode,
   input logic [FRAC_W-1:0] frac,
   input logic              sel_hi,
   input logic [FRAC_W+1:0] phase_err
);
   localparam int FULL  = 1 << FRAC_W;
   localparam int HALF  = FULL / 2;
   localparam int QUART = FULL / 4;

   int pe_i;
   int fr_i;
   assign pe_i = int'($signed(phase_err));
   assign fr_i = int'(frac);

   assert_conserve_R2: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> pe_i == $past(pe_i) + $past(fr_i) - (sel_hi ? FULL : 0));

   assert_periodic_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (mode == 2'b00 || mode == 2'b11) && pe_i >= 0 && pe_i < FULL)
      |=> (pe_i >= 0 && pe_i < FULL));

   assert_sigdel_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == 2'b10 && pe_i >= -HALF && pe_i < HALF)
      |=> (pe_i >= -HALF && pe_i < HALF));

   assert_zero_frac_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && frac == '0 && pe_i == 0) |=> (!sel_hi && pe_i == 0));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!sel_hi && $stable(pe_i)));

   assert_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pe_i >= -HALF && pe_i < FULL + QUART);
endmodule

bind fracn_modsel fracn_modsel_chk #(.FRAC_W(FRAC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .mode      (mode),
   .frac      (frac),
   .sel_hi    (sel_hi),
   .phase_err (phase_err)
);

// File: tb/fracn_modsel_tb.sv
`timescale 1ns/1ps
module fracn_modsel_tb;
   localparam int K    = 8;
   localparam int FULL = 1 << K;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           enable = 1'b0;
   logic [1:0]     mode = 2'b00;
   logic [K-1:0]   frac = '0;
   logic           sel_hi;
   logic [K+1:0]   phase_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   int m_res  = 0;
   int m_sel  = 0;
   int m_lfsr = 16'hACE1;
   int ones   = 0;

   always #2.5 clk = ~clk;

   fracn_modsel #(.FRAC_W(K)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
      .frac(frac), .sel_hi(sel_hi), .phase_err(phase_err)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One reference cycle: drive, predict, clock, compare both outputs.
   task automatic tick(input bit en, input int md, input int f, input string tag);
      int d, v, thr, y, act_pe;
      enable = en;
      mode   = md[1:0];
      frac   = f[K-1:0];
      if (en) begin
         d = m_lfsr & ((1 << (K-1)) - 1);
         if (d >= (1 << (K-2))) d -= (1 << (K-1));
         if (md != 1) d = 0;
         thr = (md == 2) ? FULL / 2 : FULL;
         v   = m_res + f;
         y   = (v + d >= thr) ? 1 : 0;
         m_res = v - y * FULL;
         m_sel = y;
         m_lfsr = (m_lfsr & 1) ? ((m_lfsr >> 1) ^ 16'hB400) : (m_lfsr >> 1);
      end else begin
         m_sel = 0;
      end
      @(posedge clk);
      #1;
      act_pe = int'($signed(phase_err));
      ones += int'(sel_hi);
      n_checks++;
      if (int'(sel_hi) != m_sel || act_pe != m_res) begin
         n_fail++;
         $display("FAIL %s: sel=%0d pe=%0d expected sel=%0d pe=%0d",
                  tag, sel_hi, act_pe, m_sel, m_res);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(150000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int lo, hi, act_pe;
      // R1 reset state
      #12;
      check("R1 sel after reset", int'(sel_hi), 0);
      check("R1 residue after reset", int'($signed(phase_err)), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R3/R4 periodic, frac 64: 1 of 4, full 2^K window
      ones = 0;
      for (int i = 0; i < FULL; i++) tick(1, 0, 64, "R3 periodic f=64");
      check("R4 ones over 2^K f=64", ones, 64);

      // R8 zero fraction in each mode from zero residue
      ones = 0;
      for (int i = 0; i < 40; i++) tick(1, i % 3, 0, "R8 zero frac");
      check("R8 no high bits with frac 0", ones, 0);
      check("R8 residue still zero", int'($signed(phase_err)), 0);

      // R4 odd fraction, mode code 11 as periodic
      ones = 0;
      for (int i = 0; i < FULL; i++) tick(1, 3, 173, "R3 periodic code11 f=173");
      check("R4 ones over 2^K f=173", ones, 173);

      // R5/R6 randomized
      ones = 0;
      for (int i = 0; i < 4096; i++) tick(1, 1, 77, "R5 random f=77");
      lo = 77 * 16 - 2;
      hi = 77 * 16 + 2;
      check("R6 random average count", (ones >= lo && ones <= hi) ? 1 : 0, 1);

      // R7 sigma-delta
      for (int i = 0; i < 300; i++) tick(1, 2, 200, "R7 sigma-delta f=200");
      for (int i = 0; i < 300; i++) tick(1, 2, 31, "R7 sigma-delta f=31");

      // R9 hold with enable low
      act_pe = int'($signed(phase_err));
      for (int i = 0; i < 10; i++) tick(0, 1, 255, "R9 disabled");
      check("R9 residue held", int'($signed(phase_err)), act_pe);
      tick(1, 1, 90, "R9 LFSR held across idle");

      // R10 mode switches colliding with decisions and idle cycles
      for (int i = 0; i < 3000; i++) begin
         tick((i % 5) != 0, (i / 7) % 4, (i * 37 + 11) % FULL, "R10 mixed modes");
         act_pe = int'($signed(phase_err));
         if (act_pe < -FULL / 2 || act_pe >= FULL + FULL / 4)
            check("R10 residue bound", act_pe, 0);
      end
      check("R10 final residue in bound",
            (int'($signed(phase_err)) >= -FULL / 2 &&
             int'($signed(phase_err)) < FULL + FULL / 4) ? 1 : 0, 1);

      // R2 conservation at one step
      act_pe = int'($signed(phase_err));
      tick(1, 0, 150, "R2 step");
      check("R2 residue conservation",
            int'($signed(phase_err)), act_pe + 150 - int'(sel_hi) * FULL);

      finish_run();
   end
endmodule